// File: doc/BRIEF.md
# Two-Level Address Translation Buffer

This block maps 32-bit virtual addresses onto 29-bit physical addresses. It holds two fully associative buffers. A 4-entry instruction-side buffer serves instruction fetches. A 64-entry unified buffer serves data lookups and also refills the instruction side. Software loads the unified buffer one entry at a time through a write port that carries an entry index. The instruction-side buffer is never written by software. It copies an entry from the unified buffer by itself whenever a fetch misses in it.

Each entry holds these fields:
- a virtual page number;
- an 8-bit space identifier;
- a page-size code;
- a physical page number;
- valid and shared flags;
- two access-right bits, one for privileged mode and one for user mode.

The page size decides how many low address bits pass through untranslated and how many bits take part in the compare. A lookup ends with one result pulse that reports one of three outcomes: a translation, a miss fault or a protection fault.

Top module: `xlat_tlb`

## Requirements
- R1: After reset all flags in both buffers are clear. No result flag (`done_o`, `hit_o`, `miss_o`, `prot_o`) is high until a request is made, and the first data lookup reports a miss.
- R2: Page-size code 00 = 1 KB, 01 = 4 KB, 10 = 64 KB, 11 = 1 MB. On a hit, `pa_o` takes its low 10, 12, 16 or 20 bits from `va_i`. It takes the remaining bits up to bit 28 from the physical page number, which stands for `pa_o[28:10]`. The virtual page number stands for `va_i[31:10]`, and its low 0, 2, 6 or 10 bits are left out of the compare.
- R3: An entry with the shared flag set matches under any `asid_i`. An entry without it matches only when its identifier equals `asid_i`.
- R4: A fetch (`ifetch_i`=1) that hits the instruction-side buffer completes one cycle after acceptance. A fetch that misses there but hits the unified buffer completes three cycles after acceptance and installs the entry, so a repeat fetch of the same page completes in one cycle.
- R5: A data lookup (`ifetch_i`=0) that misses the unified buffer raises `miss_o` one cycle after acceptance. A fetch that misses both buffers raises it two cycles after acceptance. In both cases neither buffer changes, so a repeated fetch misses the same way.
- R6: Right bit 0 allows privileged access (`priv_i`=1) and bit 1 allows user access. A matching entry whose right bit for the current mode is 0 gives `prot_o` with `hit_o`=0 and `pa_o`=0.
- R7: Instruction-side refills replace slots 0,1,2,3,0,... in turn, driven by a 2-bit pointer that advances on each refill.
- R8: A software write to any unified-buffer entry invalidates every instruction-side entry.
- R9: While a refill is in progress, `req_i` is ignored. Each accepted request yields exactly one `done_o` pulse.
- R10: `done_o` is a single-cycle pulse. When it is high, exactly one of `hit_o`, `miss_o`, `prot_o` is high. When it is low, all three are low.
- R11: When several unified entries match, the lowest index is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| asid_i | input | 8 | Current space identifier |
| priv_i | input | 1 | 1 = privileged mode, 0 = user mode |
| req_i | input | 1 | Lookup request |
| ifetch_i | input | 1 | 1 = instruction fetch, 0 = data lookup |
| va_i | input | 32 | Virtual address |
| wr_en_i | input | 1 | Write one unified-buffer entry |
| wr_idx_i | input | 6 | Index of the entry written |
| wr_vpn_i | input | 22 | Virtual page number (`va[31:10]`) |
| wr_ppn_i | input | 19 | Physical page number (`pa[28:10]`) |
| wr_asid_i | input | 8 | Entry space identifier |
| wr_size_i | input | 2 | Page-size code |
| wr_valid_i | input | 1 | Entry valid |
| wr_shared_i | input | 1 | Entry shared |
| wr_rights_i | input | 2 | Bit 0 privileged, bit 1 user allowed |
| done_o | output | 1 | Result pulse |
| hit_o | output | 1 | Translation delivered |
| miss_o | output | 1 | Miss fault |
| prot_o | output | 1 | Protection fault |
| pa_o | output | 29 | Physical address (0 unless hit) |

## Verification
Stale or misplaced instruction-side contents show up at the ports as a wrong latency before they show up as a wrong address. A one-cycle result where three are due means an invalidation or replacement went wrong. A three-cycle result where one is due means the wrong slot was overwritten. Either is visible on the very next fetch of the affected page. A wrong size mask or a wrong priority choice in the unified buffer appears at once as a wrong `pa_o` or a wrong fault kind. A stuck refill state appears as a missing or doubled `done_o` pulse. The bench tracks both buffers and the replacement pointer, and compares latency, outcome and address on every lookup.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 29;
  localparam int ASID_W  = 8;
  localparam int OFF_MIN = 10;
  localparam int VPN_W   = VA_W - OFF_MIN;
  localparam int PPN_W   = PA_W - OFF_MIN;

  typedef enum logic [1:0] {PG_1K = 2'b00, PG_4K = 2'b01, PG_64K = 2'b10, PG_1M = 2'b11} pg_size_e;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [1:0]        rights;  // [0] privileged, [1] user
    pg_size_e          size;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
  } xlat_ent_t;

  // 1 = page-number bit takes part in compare / translation
  function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
    case (s)
      PG_1K:   return '1;
      PG_4K:   return ~VPN_W'(3);
      PG_64K:  return ~VPN_W'(63);
      default: return ~VPN_W'(1023);
    endcase
  endfunction

  function automatic logic ent_match(xlat_ent_t e, logic [VA_W-1:0] va, logic [ASID_W-1:0] asid);
    logic [VPN_W-1:0] m;
    m = vpn_mask(e.size);
    return e.valid && (e.shared || e.asid == asid) &&
           (((e.vpn ^ va[VA_W-1:OFF_MIN]) & m) == '0);
  endfunction

  function automatic logic [PA_W-1:0] ent_pa(xlat_ent_t e, logic [VA_W-1:0] va);
    logic [VPN_W-1:0] mf;
    logic [PPN_W-1:0] m;
    mf = vpn_mask(e.size);
    m  = mf[PPN_W-1:0];
    return {(e.ppn & m) | (va[PA_W-1:OFF_MIN] & ~m), va[OFF_MIN-1:0]};
  endfunction

  function automatic logic rights_ok(xlat_ent_t e, logic priv);
    return priv ? e.rights[0] : e.rights[1];
  endfunction
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam import xlat_pkg::*; #(
  parameter int unsigned N = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [$clog2(N)-1:0] wr_idx_i,
  input  xlat_ent_t            wr_ent_i,
  input  logic                 inv_all_i,
  input  logic [VA_W-1:0]      va_i,
  input  logic [ASID_W-1:0]    asid_i,
  output logic                 hit_o,
  output xlat_ent_t            ent_o
);
  xlat_ent_t tab_q [N];
  logic [N-1:0] hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) tab_q[i] <= '0;
    end else begin
      if (wr_en_i) tab_q[wr_idx_i] <= wr_ent_i;
      if (inv_all_i)
        for (int i = 0; i < N; i++) tab_q[i].valid <= 1'b0;  // invalidate wins
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_match(tab_q[g], va_i, asid_i);
  end

  // lowest index wins
  always_comb begin
    ent_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit_vec[i]) ent_o = tab_q[i];
  end
  assign hit_o = |hit_vec;

  // R8: no entry matches right after a global invalidate
  p_inv_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inv_all_i) |-> hit_vec == '0);
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb import xlat_pkg::*; #(
  parameter int unsigned IENT = 4,
  parameter int unsigned UENT = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ASID_W-1:0]       asid_i,
  input  logic                    priv_i,
  input  logic                    req_i,
  input  logic                    ifetch_i,
  input  logic [VA_W-1:0]         va_i,
  input  logic                    wr_en_i,
  input  logic [$clog2(UENT)-1:0] wr_idx_i,
  input  logic [VPN_W-1:0]        wr_vpn_i,
  input  logic [PPN_W-1:0]        wr_ppn_i,
  input  logic [ASID_W-1:0]       wr_asid_i,
  input  logic [1:0]              wr_size_i,
  input  logic                    wr_valid_i,
  input  logic                    wr_shared_i,
  input  logic [1:0]              wr_rights_i,
  output logic                    done_o,
  output logic                    hit_o,
  output logic                    miss_o,
  output logic                    prot_o,
  output logic [PA_W-1:0]         pa_o
);
  localparam int IIDX_W = $clog2(IENT);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FIN} st_e;

  st_e               st_q, st_n;
  logic [VA_W-1:0]   va_q;
  logic [ASID_W-1:0] asid_q;
  logic              priv_q;
  xlat_ent_t         fill_q, wr_ent, ib_ent, ut_ent, fin_ent;
  logic [IIDX_W-1:0] rr_q;
  logic              ib_hit, ut_hit, accept, ib_wr, fin, miss_n, ok;
  logic [VA_W-1:0]   fin_va, ut_va;
  logic [ASID_W-1:0] ut_asid;
  logic              fin_priv;

  always_comb begin
    wr_ent        = '0;
    wr_ent.valid  = wr_valid_i;
    wr_ent.shared = wr_shared_i;
    wr_ent.rights = wr_rights_i;
    wr_ent.size   = pg_size_e'(wr_size_i);
    wr_ent.asid   = wr_asid_i;
    wr_ent.vpn    = wr_vpn_i;
    wr_ent.ppn    = wr_ppn_i;
  end

  assign accept  = req_i && (st_q == ST_IDLE);
  assign ut_va   = (st_q == ST_LOOK) ? va_q : va_i;
  assign ut_asid = (st_q == ST_LOOK) ? asid_q : asid_i;
  assign ib_wr   = (st_q == ST_LOOK) && ut_hit;

  xlat_cam #(.N(IENT)) u_ibuf (
    .clk_i, .rst_ni,
    .wr_en_i(ib_wr), .wr_idx_i(rr_q), .wr_ent_i(ut_ent),
    .inv_all_i(wr_en_i),
    .va_i(va_i), .asid_i(asid_i),
    .hit_o(ib_hit), .ent_o(ib_ent)
  );

  xlat_cam #(.N(UENT)) u_ubuf (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_ent_i(wr_ent),
    .inv_all_i(1'b0),
    .va_i(ut_va), .asid_i(ut_asid),
    .hit_o(ut_hit), .ent_o(ut_ent)
  );

  always_comb begin
    st_n     = st_q;
    fin      = 1'b0;
    miss_n   = 1'b0;
    fin_ent  = ib_ent;
    fin_va   = va_i;
    fin_priv = priv_i;
    case (st_q)
      ST_IDLE: if (accept) begin
        if (ifetch_i) begin
          if (ib_hit) fin = 1'b1;
          else        st_n = ST_LOOK;
        end else if (ut_hit) begin
          fin     = 1'b1;
          fin_ent = ut_ent;
        end else miss_n = 1'b1;
      end
      ST_LOOK: begin
        if (ut_hit) st_n = ST_FIN;
        else begin
          miss_n = 1'b1;
          st_n   = ST_IDLE;
        end
      end
      default: begin  // ST_FIN: result from the captured refill entry
        fin      = 1'b1;
        fin_ent  = fill_q;
        fin_va   = va_q;
        fin_priv = priv_q;
        st_n     = ST_IDLE;
      end
    endcase
    ok = rights_ok(fin_ent, fin_priv);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      asid_q <= '0;
      priv_q <= 1'b0;
      fill_q <= '0;
      rr_q   <= '0;
      done_o <= 1'b0;
      hit_o  <= 1'b0;
      miss_o <= 1'b0;
      prot_o <= 1'b0;
      pa_o   <= '0;
    end else begin
      st_q   <= st_n;
      done_o <= fin | miss_n;
      hit_o  <= fin & ok;
      prot_o <= fin & ~ok;
      miss_o <= miss_n;
      pa_o   <= (fin && ok) ? ent_pa(fin_ent, fin_va) : '0;
      if (accept) begin
        va_q   <= va_i;
        asid_q <= asid_i;
        priv_q <= priv_i;
      end
      if (ib_wr) begin
        fill_q <= ut_ent;
        rr_q   <= rr_q + 1'b1;
      end
    end
  end

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({hit_o, miss_o, prot_o}) == 1);
  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(hit_o || miss_o || prot_o));
  p_prot_nopa_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_o |-> pa_o == '0);
  p_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && $past(st_q == ST_IDLE)) |-> pa_o[OFF_MIN-1:0] == $past(va_i[OFF_MIN-1:0]));
  p_fin_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(st_q == ST_FIN) |-> (done_o && !miss_o));
  p_one_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(st_q == ST_IDLE)) |-> $past(req_i));
endmodule

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;
  import xlat_pkg::*;

  logic              clk_i = 1'b0, rst_ni = 1'b0;
  logic [ASID_W-1:0] asid_i = '0;
  logic              priv_i = 1'b0, req_i = 1'b0, ifetch_i = 1'b0;
  logic [VA_W-1:0]   va_i = '0;
  logic              wr_en_i = 1'b0;
  logic [5:0]        wr_idx_i = '0;
  logic [VPN_W-1:0]  wr_vpn_i = '0;
  logic [PPN_W-1:0]  wr_ppn_i = '0;
  logic [ASID_W-1:0] wr_asid_i = '0;
  logic [1:0]        wr_size_i = '0;
  logic              wr_valid_i = 1'b0, wr_shared_i = 1'b0;
  logic [1:0]        wr_rights_i = '0;
  logic              done_o, hit_o, miss_o, prot_o;
  logic [PA_W-1:0]   pa_o;

  xlat_tlb uut (.*);

  always #2 clk_i = ~clk_i;  // 250 MHz

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  xlat_ent_t um [64];
  xlat_ent_t im [4];
  int rr = 0;

  task automatic chk(bit good, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int lowb(logic [1:0] s);
    case (s)
      2'b00: return 0;
      2'b01: return 2;
      2'b10: return 6;
      default: return 10;
    endcase
  endfunction

  function automatic bit mmatch(xlat_ent_t e, logic [31:0] va, logic [7:0] asid);
    int lb = lowb(e.size);
    logic [21:0] a = e.vpn >> lb, b = va[31:10] >> lb;
    return e.valid && (e.shared || e.asid == asid) && a == b;
  endfunction

  function automatic logic [28:0] mpa(xlat_ent_t e, logic [31:0] va);
    logic [31:0] m = (32'd1 << (10 + lowb(e.size))) - 1;
    logic [31:0] p = {3'b0, e.ppn, 10'b0};
    logic [31:0] r = (p & ~m) | (va & m);
    return r[28:0];
  endfunction

  function automatic xlat_ent_t mk(logic [31:0] va, logic [7:0] asid, logic [1:0] sz,
                                   logic [18:0] ppn, bit sh, logic [1:0] rt);
    xlat_ent_t e;
    e.valid = 1'b1; e.shared = sh; e.rights = rt; e.size = pg_size_e'(sz);
    e.asid = asid; e.vpn = va[31:10]; e.ppn = ppn;
    return e;
  endfunction

  task automatic wr(int idx, xlat_ent_t e);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 6'(idx); wr_vpn_i = e.vpn; wr_ppn_i = e.ppn;
    wr_asid_i = e.asid; wr_size_i = e.size; wr_valid_i = e.valid;
    wr_shared_i = e.shared; wr_rights_i = e.rights;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    um[idx] = e;
    for (int i = 0; i < 4; i++) im[i].valid = 1'b0;
  endtask

  task automatic look(logic [31:0] va, bit ifet, bit prv, logic [7:0] asd, bit hold, string tag);
    int ui = -1, ii = -1, elat, lat;
    bit eh = 0, em = 0, ep = 0;
    logic [28:0] epa = '0;
    xlat_ent_t e;
    for (int i = 63; i >= 0; i--) if (mmatch(um[i], va, asd)) ui = i;
    for (int i = 3; i >= 0; i--) if (mmatch(im[i], va, asd)) ii = i;
    if (ifet && ii >= 0) begin elat = 1; e = im[ii]; end
    else if (ifet && ui >= 0) begin elat = 3; e = um[ui]; im[rr] = um[ui]; rr = (rr + 1) % 4; end
    else if (ifet) begin elat = 2; em = 1; end
    else if (ui >= 0) begin elat = 1; e = um[ui]; end
    else begin elat = 1; em = 1; end
    if (!em) begin
      if (prv ? e.rights[0] : e.rights[1]) begin eh = 1; epa = mpa(e, va); end
      else ep = 1;
    end
    @(negedge clk_i);
    req_i = 1'b1; va_i = va; ifetch_i = ifet; priv_i = prv; asid_i = asd;
    lat = 0;
    do begin
      @(negedge clk_i);
      lat++;
      if (!hold || done_o) req_i = 1'b0;
      else va_i = $urandom;
    end while (!done_o && lat < 6);
    req_i = 1'b0;
    chk(lat == elat, (ifet && elat != 2) ? tag : "R4", "latency", lat, elat);
    chk({hit_o, miss_o, prot_o} == {eh, em, ep}, tag, "outcome hit/miss/prot", {hit_o, miss_o, prot_o}, {eh, em, ep});
    chk(pa_o == epa, tag, "pa", pa_o, epa);
    if (hold) begin
      @(negedge clk_i); chk(done_o == 1'b0, "R9", "extra done", done_o, 0);
      @(negedge clk_i); chk(done_o == 1'b0, "R9", "extra done", done_o, 0);
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) um[i] = '0;
    for (int i = 0; i < 4; i++) im[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: quiet after reset, empty buffers
    chk({done_o, hit_o, miss_o, prot_o} == 4'b0, "R1", "flags after reset", {done_o, hit_o, miss_o, prot_o}, 0);
    look(32'h0000_0000, 0, 1, 8'd3, 0, "R1");
    // R2: each page size
    wr(1, mk(32'h1234_5400, 8'd3, 2'b00, 19'h0ABCD, 0, 2'b11));
    wr(2, mk(32'h2000_0000, 8'd3, 2'b01, 19'h12345, 0, 2'b11));
    wr(3, mk(32'h3001_0000, 8'd3, 2'b10, 19'h7FFFF, 0, 2'b11));
    wr(4, mk(32'h4010_0000, 8'd3, 2'b11, 19'h55555, 0, 2'b11));
    look(32'h1234_57FF, 0, 1, 8'd3, 0, "R2");
    look(32'h2000_0ABC, 0, 1, 8'd3, 0, "R2");
    look(32'h3001_F123, 0, 0, 8'd3, 0, "R2");
    look(32'h401F_FFFF, 0, 0, 8'd3, 0, "R2");
    look(32'h2000_1000, 0, 1, 8'd3, 0, "R2");  // just outside the 4K page
    // R3: identifier qualification
    look(32'h1234_5400, 0, 1, 8'd4, 0, "R3");
    wr(5, mk(32'h5000_0000, 8'd9, 2'b01, 19'h00111, 1, 2'b11));
    look(32'h5000_0004, 0, 1, 8'd4, 0, "R3");
    // R6: access rights per mode
    wr(6, mk(32'h6000_0000, 8'd3, 2'b00, 19'h06060, 0, 2'b01));
    wr(7, mk(32'h6100_0000, 8'd3, 2'b00, 19'h06161, 0, 2'b10));
    look(32'h6000_0010, 0, 0, 8'd3, 0, "R6");
    look(32'h6000_0010, 0, 1, 8'd3, 0, "R6");
    look(32'h6100_0010, 0, 1, 8'd3, 0, "R6");
    look(32'h6100_0010, 0, 0, 8'd3, 0, "R6");
    // R11: lowest index wins
    wr(11, mk(32'h7000_0000, 8'd3, 2'b00, 19'h0BBBB, 0, 2'b11));
    wr(10, mk(32'h7000_0000, 8'd3, 2'b00, 19'h0AAAA, 0, 2'b11));
    look(32'h7000_0020, 0, 1, 8'd3, 0, "R11");
    // R4: refill then fast hit
    look(32'h1234_5500, 1, 1, 8'd3, 0, "R4");
    look(32'h1234_5504, 1, 1, 8'd3, 0, "R4");
    // R5: double miss leaves buffers unchanged
    look(32'h7777_0000, 1, 1, 8'd3, 0, "R5");
    look(32'h7777_0000, 1, 1, 8'd3, 0, "R5");
    // R7: round-robin replacement
    look(32'h2000_0100, 1, 1, 8'd3, 0, "R7");
    look(32'h3001_0100, 1, 1, 8'd3, 0, "R7");
    look(32'h4010_0100, 1, 1, 8'd3, 0, "R7");
    look(32'h5000_0100, 1, 1, 8'd3, 0, "R7");
    look(32'h2000_0200, 1, 1, 8'd3, 0, "R7");
    look(32'h1234_5600, 1, 1, 8'd3, 0, "R7");
    // R8: write invalidates instruction side
    wr(20, mk(32'h0F00_0000, 8'd3, 2'b00, 19'h00F0F, 0, 2'b11));
    look(32'h1234_5600, 1, 1, 8'd3, 0, "R8");
    // R9: requests held during refill are ignored
    look(32'h3001_0200, 1, 1, 8'd3, 1, "R9");
    // random mix
    for (int it = 0; it < 500; it++) begin
      logic [31:0] msk, base, va;
      case ($urandom % 4)
        0: msk = 32'h3FF; 1: msk = 32'hFFF; 2: msk = 32'hFFFF; default: msk = 32'hF_FFFF;
      endcase
      base = 32'h8000_0000 | (($urandom % 4) << 22);
      va = base | ($urandom & msk);
      if ($urandom % 4 == 0)
        wr($urandom % 64, mk(va, 8'($urandom % 2 + 3), 2'($urandom), 19'($urandom),
                             ($urandom % 4 == 0), 2'($urandom)));
      else
        look(va, $urandom % 2, $urandom % 2, 8'($urandom % 2 + 3), 0, "R10");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule